// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller with Pull-ups

This block generates the pad-control signals for an 8-bit bidirectional general-purpose I/O port. Each bit holds a direction flag and a drive-value flag. From these it produces a per-pin output enable, a per-pin output value and a per-pin pull-up enable. The pin levels seen on the pads pass through a two-stage synchronizer, and software can read the result. A small write/read bus with a 2-bit register select gives access to the direction register, the drive-value register and the synchronized pin view.

Reset is active low. Its assertion takes effect without a clock and tri-states every pin at once. Its release is synchronized to the clock. A debug-interface enable input forces the pull-ups on three fixed pins at all times, during reset as well. These pins carry the debug signals and must not float.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction and drive-value registers read 0x00, and `pin_oe_o`, `pin_out_o` and `pull_en_o` are all 0x00 while `dbg_en_i` is low.
- R2: A write with `reg_sel_i` = 0 stores `wr_data_i` as the direction register at that rising edge, and `pin_oe_o` equals it from then on (1 = output).
- R3: A write with `reg_sel_i` = 1 stores `wr_data_i` as the drive-value register at that rising edge, and `pin_out_o` equals it from then on.
- R4: For each bit, `pull_en_o` is 1 exactly when the direction bit is 0 and the drive-value bit is 1, apart from the debug override of R8.
- R5: `rd_data_o` returns the direction register for select 0 and the drive-value register for select 1.
- R6: With select 2, `rd_data_o` shows `pin_i` as it was sampled two rising edges earlier, so a change is not visible after one edge and is visible after two.
- R7: Writes with select 2 or 3 change neither register, and reads with select 3 return 0x00.
- R8: While `dbg_en_i` is high, bits 5, 3 and 2 of `pull_en_o` are 1 (mask 0x2C), in reset and out of it.
- R9: Driving `rst_ni` low forces `pin_oe_o` to 0x00 immediately, with no clock edge needed.
- R10: Reset release is synchronized through two flops. A write held from the release onward takes effect at the third rising edge after `rst_ni` goes high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 direction, 1 drive value, 2 pin view, 3 reserved |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for the selected register |
| dbg_en_i | input | 1 | Debug-interface enable, forces pull-ups on bits 5, 3, 2 |
| pin_i | input | 8 | Pad input levels |
| pin_oe_o | output | 8 | Pad output enable per bit |
| pin_out_o | output | 8 | Pad output value per bit |
| pull_en_o | output | 8 | Pad pull-up enable per bit |

## Verification
A corrupted direction bit appears on `pin_oe_o`, and also inverts that bit's pull-up term, in the cycle after the bad write. A corrupted drive-value bit appears on `pin_out_o` and `pull_en_o` in that same cycle. Synchronizer depth faults show up as a pin change that becomes visible one edge early or late on the select-2 read. Reset faults show as a nonzero output enable in the instant after `rst_ni` falls, or as a write taking effect before the third edge after release. A missing debug override shows as any of bits 5, 3, 2 low on `pull_en_o` while reset is held.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_DIR = 2'd0,
    SEL_OUT = 2'd1,
    SEL_PIN = 2'd2,
    SEL_RSV = 2'd3
  } gpio_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // data path only: no reset, values settle after STAGES edges
  always_ff @(posedge clk_i) stage_q[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) stage_q[s] <= stage_q[s-1];
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  gpio_sel_e        sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] out_o
);
  logic [WIDTH-1:0] dir_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_en_i) begin
      if (sel_i == SEL_DIR) dir_q <= wr_data_i;
      if (sel_i == SEL_OUT) out_q <= wr_data_i;
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH         = 8,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned RST_STAGES    = 2,
  parameter logic [7:0]  DBG_PULL_MASK = 8'h2C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             dbg_en_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic [WIDTH-1:0] pin_out_o,
  output logic [WIDTH-1:0] pull_en_o
);
  localparam logic [WIDTH-1:0] DbgMask = WIDTH'(DBG_PULL_MASK);

  logic             rst_sync_n;
  logic [WIDTH-1:0] dir_q, out_q, pin_sync;
  gpio_sel_e        sel;

  assign sel = gpio_sel_e'(reg_sel_i);

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_in (
    .clk_i(clk_i),
    .d_i  (pin_i),
    .q_o  (pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .wr_en_i  (wr_en_i),
    .sel_i    (sel),
    .wr_data_i(wr_data_i),
    .dir_o    (dir_q),
    .out_o    (out_q)
  );

  // registers clear asynchronously through the reset chain, so no clock is needed
  assign pin_oe_o  = dir_q;
  assign pin_out_o = out_q;
  assign pull_en_o = (~dir_q & out_q) | (dbg_en_i ? DbgMask : '0);

  always_comb begin
    unique case (sel)
      SEL_DIR: rd_data_o = dir_q;
      SEL_OUT: rd_data_o = out_q;
      SEL_PIN: rd_data_o = pin_sync;
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int unsigned WIDTH         = 8,
  parameter logic [7:0]  DBG_PULL_MASK = 8'h2C
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_sync_ni,
  input logic             wr_en_i,
  input logic [1:0]       reg_sel_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             dbg_en_i,
  input logic [WIDTH-1:0] pin_i,
  input logic [WIDTH-1:0] pin_oe_o,
  input logic [WIDTH-1:0] pin_out_o,
  input logic [WIDTH-1:0] pull_en_o
);
  localparam logic [WIDTH-1:0] DbgMask = WIDTH'(DBG_PULL_MASK);

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_sync_ni && wr_en_i && reg_sel_i == 2'd0) |=> (pin_oe_o == $past(wr_data_i))); // R2

  AST_OUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_sync_ni && wr_en_i && reg_sel_i == 2'd1) |=> (pin_out_o == $past(wr_data_i))); // R3

  AST_PULL_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_en_i |-> (pull_en_o == (~pin_oe_o & pin_out_o))); // R4

  AST_PIN_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'd2 && $past(rst_ni) && $past(rst_ni, 2)) |-> (rd_data_o == $past(pin_i, 2))); // R6

  AST_RSV_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'd3) |-> (rd_data_o == '0)); // R7

  AST_DBG_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_en_i |-> ((pull_en_o & DbgMask) == DbgMask)); // R8

  AST_NO_WRITE_IN_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_sync_ni |-> (pin_oe_o == '0 && pin_out_o == '0)); // R10
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.WIDTH(WIDTH), .DBG_PULL_MASK(DBG_PULL_MASK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_sync_ni(rst_sync_n),
  .wr_en_i    (wr_en_i),
  .reg_sel_i  (reg_sel_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .dbg_en_i   (dbg_en_i),
  .pin_i      (pin_i),
  .pin_oe_o   (pin_oe_o),
  .pin_out_o  (pin_out_o),
  .pull_en_o  (pull_en_o)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] reg_sel_i = 2'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       dbg_en_i = 1'b0;
  logic [7:0] pin_i = 8'h00;
  logic [7:0] pin_oe_o, pin_out_o, pull_en_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  gpio_port_ctrl dut (
    .clk_i, .rst_ni, .wr_en_i, .reg_sel_i, .wr_data_i, .rd_data_o,
    .dbg_en_i, .pin_i, .pin_oe_o, .pin_out_o, .pull_en_o
  );

  // {sel, data, exp_dir, exp_out, exp_pull}
  localparam int NV = 8;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 8'hF0, 8'hF0, 8'h00, 8'h00},
    {2'd1, 8'hAA, 8'hF0, 8'hAA, 8'h0A},
    {2'd2, 8'hFF, 8'hF0, 8'hAA, 8'h0A},
    {2'd3, 8'h55, 8'hF0, 8'hAA, 8'h0A},
    {2'd0, 8'h0F, 8'h0F, 8'hAA, 8'hA0},
    {2'd1, 8'hFF, 8'h0F, 8'hFF, 8'hF0},
    {2'd0, 8'h00, 8'h00, 8'hFF, 8'hFF},
    {2'd0, 8'hFF, 8'hFF, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, input string req, input logic [7:0] exp);
    reg_sel_i = s;
    #0.5;
    chk(req, rd_data_o, exp);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; reg_sel_i = s; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 oe", pin_oe_o, 8'h00);
    chk("R1 out", pin_out_o, 8'h00);
    chk("R1 pull", pull_en_o, 8'h00);
    rd(2'd0, "R1 dir read", 8'h00);
    rd(2'd1, "R1 out read", 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][33:32], VEC[i][31:24]);
      chk("R2 oe", pin_oe_o, VEC[i][23:16]);
      chk("R3 out", pin_out_o, VEC[i][15:8]);
      chk("R4 pull", pull_en_o, VEC[i][7:0]);
      rd(2'd0, "R5/R7 dir read", VEC[i][23:16]);
      rd(2'd1, "R5/R7 out read", VEC[i][15:8]);
    end
    rd(2'd3, "R7 reserved read", 8'h00);

    // R6: synchronizer depth
    @(negedge clk_i); pin_i = 8'h00; reg_sel_i = 2'd2;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); pin_i = 8'h5A;
    @(posedge clk_i); #1;
    chk("R6 one edge", rd_data_o, 8'h00);
    @(posedge clk_i); #1;
    chk("R6 two edges", rd_data_o, 8'h5A);

    // R8: debug pull-up override with all outputs (dir=FF out=FF)
    @(negedge clk_i); dbg_en_i = 1'b1;
    #0.5;
    chk("R8 dbg run", pull_en_o, 8'h2C);

    // R9: async reset mid high phase, no edge
    @(posedge clk_i); #0.5;
    chk("R9 pre", pin_oe_o, 8'hFF);
    rst_ni = 1'b0;
    #0.5;
    chk("R9 oe immediate", pin_oe_o, 8'h00);
    chk("R8 dbg in reset", pull_en_o, 8'h2C);
    dbg_en_i = 1'b0;
    #0.5;
    chk("R1 pull in reset", pull_en_o, 8'h00);

    // R10: synchronized release
    @(negedge clk_i);
    rst_ni = 1'b1; wr_en_i = 1'b1; reg_sel_i = 2'd0; wr_data_i = 8'h3C;
    @(posedge clk_i); @(posedge clk_i); #1;
    chk("R10 second edge", rd_data_o, 8'h00);
    @(posedge clk_i); #1;
    chk("R10 third edge", rd_data_o, 8'h3C);
    wr_en_i = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule